// File: doc/BRIEF.md
# Periodic Interval Timer

The block is a memory-mapped timer that produces a steady stream of period events. A fixed divide-by-16 prescaler runs off the master clock. Each prescaler tick advances a 20-bit counter, which climbs from zero up to a programmed limit and then returns to zero. Each return to zero counts as one finished period. A 12-bit tally records how many periods have finished since software last acknowledged. A sticky flag records that at least one period has finished. When interrupts are enabled, the flag drives a level interrupt.

Software uses a single-cycle register port with address, write enable, write data, read enable and read data. Read data is combinational, so it is valid in the same cycle as the read enable. Any side effect of a read takes place at the clock edge that ends that cycle. The counter word can be read in two ways. One read acknowledges the event: it clears the tally and the flag. The other read changes no state.

When the enable bit is cleared, the counter does not stop at once. It runs on to the end of the current period and then rests at zero. Software can poll for a zero count to learn that the timer has halted.

Top module: `pit_timer`

## Requirements
- R1: After reset, reads at all four addresses return zero and `irq` is low.
- R2: While running, the current-value field goes up by exactly one every 16 master-clock cycles. The first step lands 16 edges after the clock edge that wrote the enable bit.
- R3: The current value counts 0, 1, …, L, where L is the mode limit field. It then returns to 0. Each return adds one to the period tally and sets the status flag. A period therefore lasts (L+1)·16 cycles.
- R4: A read at offset 0x8 returns the tally in bits 31:20 and the current value in bits 19:0. The same read clears the tally and the flag.
- R5: A read at offset 0xC returns the same word as offset 0x8 and changes no state.
- R6: `irq` is high exactly when the status flag and the interrupt-enable bit are both set. It stays high until an acknowledging read.
- R7: With enable set and interrupt-enable clear, counting, the tally and the flag all keep going, but `irq` stays low.
- R8: After the enable bit is cleared, the counter runs on until it returns to 0. That return still counts as a period. The counter then holds at 0. On re-enable, the prescaler restarts from zero.
- R9: The tally wraps modulo 4096 when periods keep finishing with no acknowledging read.
- R10: If a period finishes at the same edge as an acknowledging read, the tally becomes 1 and the flag stays set.
- R11: The mode register is at offset 0x0 and reads back what was written. Its layout is: limit in bits 19:0, enable in bit 24, interrupt-enable in bit 25. The status register is at offset 0x4, with the flag in bit 0. Writes to any other offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; an acknowledging read has its effect at the clock edge |
| bus_rdata | output | 32 | Combinational read data, zero when no read is requested |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume the enable bit changes only through a mode-register write. The halt and interrupt-hold checks exclude cycles that carry such a write. The counter-step property assumes the limit is never lowered below the live count while the timer runs. To keep to this, the bench changes the limit only right after a reset, while the counter sits at zero. The bench also issues acknowledging reads at exact cycles, to reach the coincident wrap-and-acknowledge case.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int PRESC_DIV = 16;
    localparam int VAL_W     = 20;
    localparam int PCNT_W    = 12;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int EN_BIT    = 24;
    localparam int IE_BIT    = 25;
    localparam int OFS_MODE  = 'h0;
    localparam int OFS_STAT  = 'h4;
    localparam int OFS_VALUE = 'h8;
    localparam int OFS_IMAGE = 'hC;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int VAL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [VAL_W-1:0] limit,
    output logic [VAL_W-1:0] cur,
    output logic             wrap
);
    logic [VAL_W-1:0] cur_d, cur_q;

    always_comb begin
        wrap  = tick && (cur_q >= limit);
        cur_d = cur_q;
        if (wrap) begin
            cur_d = '0;
        end else if (tick) begin
            cur_d = cur_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/pit_events.sv
module pit_events #(
    parameter int PCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              ack,
    output logic [PCNT_W-1:0] pcnt,
    output logic              flag
);
    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
        logic              flag;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        if (ack) begin
            ev_d.pcnt = wrap ? PCNT_W'(1) : '0;
            ev_d.flag = wrap;
        end else if (wrap) begin
            ev_d.pcnt = ev_q.pcnt + 1'b1;
            ev_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign pcnt = ev_q.pcnt;
    assign flag = ev_q.flag;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DIV      = PRESC_DIV,
    parameter int CNT_W    = VAL_W,
    parameter int TALLY_W  = PCNT_W,
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam logic [AW-1:0] A_MODE  = AW'(OFS_MODE);
    localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_VALUE = AW'(OFS_VALUE);
    localparam logic [AW-1:0] A_IMAGE = AW'(OFS_IMAGE);

    typedef struct packed {
        logic             ie;
        logic             en;
        logic [CNT_W-1:0] limit;
    } mode_t;

    mode_t mode_d, mode_q;

    logic               tick, wrap, run, ack, mode_we, flag;
    logic               en_q, ie_q;
    logic [CNT_W-1:0]   cur;
    logic [TALLY_W-1:0] pcnt;
    logic               unused_wdata;

    assign mode_we      = bus_we && (bus_addr == A_MODE);
    assign ack          = bus_re && (bus_addr == A_VALUE);
    assign en_q         = mode_q.en;
    assign ie_q         = mode_q.ie;
    assign run          = en_q || (cur != '0);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        mode_d = mode_q;
        if (mode_we) begin
            mode_d.limit = bus_wdata[CNT_W-1:0];
            mode_d.en    = bus_wdata[EN_BIT];
            mode_d.ie    = bus_wdata[IE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    pit_prescale #(.DIV(DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    pit_counter #(.VAL_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .limit (mode_q.limit),
        .cur   (cur),
        .wrap  (wrap)
    );

    pit_events #(.PCNT_W(TALLY_W)) u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .ack   (ack),
        .pcnt  (pcnt),
        .flag  (flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == A_MODE) begin
                bus_rdata[CNT_W-1:0] = mode_q.limit;
                bus_rdata[EN_BIT]    = mode_q.en;
                bus_rdata[IE_BIT]    = mode_q.ie;
            end else if (bus_addr == A_STAT) begin
                bus_rdata[0] = flag;
            end else if (bus_addr == A_VALUE || bus_addr == A_IMAGE) begin
                bus_rdata = DW'({pcnt, cur});
            end
        end
    end

    assign irq = flag & ie_q;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_q,
    input logic               irq,
    input logic               tick,
    input logic               wrap,
    input logic               ack,
    input logic               mode_we,
    input logic [CNT_W-1:0]   cur,
    input logic [TALLY_W-1:0] pcnt,
    input logic               flag
);
    // R2: the count moves only by one step or back to zero
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != $past(cur)) |-> (cur == CNT_W'($past(cur) + 1'b1) || cur == '0));

    // R2: no movement without a prescaler tick
    a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur));

    // R4: acknowledge without a coincident wrap empties the tally
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (pcnt == '0 && !flag));

    // R5: with neither wrap nor acknowledge the event state holds
    a_r5_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !ack) |=> ($stable(pcnt) && $stable(flag)));

    // R6: a raised interrupt holds until acknowledged or reconfigured
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !mode_we) |=> irq);

    // R8: once halted at zero with enable clear, it stays there
    a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && cur == '0 && !mode_we) |=> cur == '0);

    // R9: each unacknowledged wrap adds one, modulo the tally width
    a_r9_tally_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ack) |=> (pcnt == TALLY_W'($past(pcnt) + 1'b1) && flag));

    // R10: wrap coincident with acknowledge keeps the event
    a_r10_race: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ack) |=> (pcnt == TALLY_W'(1) && flag));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_q    (en_q),
    .irq     (irq),
    .tick    (tick),
    .wrap    (wrap),
    .ack     (ack),
    .mode_we (mode_we),
    .cur     (cur),
    .pcnt    (pcnt),
    .flag    (flag)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int t0 = 0;
    int lim = 0;
    int base = 0;
    bit ie_m = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pit_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_re   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] mode_word(input int l, input bit en, input bit ie);
        return (32'(ie) << 25) | (32'(en) << 24) | 32'(l);
    endfunction

    function automatic int periods(input int c);
        return ((c - t0) / 16) / (lim + 1);
    endfunction

    function automatic logic [31:0] exp_word(input int c);
        int tk = (c - t0) / 16;
        return {12'((periods(c) - base) % 4096), 20'(tk % (lim + 1))};
    endfunction

    task automatic start(input int l, input bit ie);
        lim  = l;
        ie_m = ie;
        base = 0;
        t0   = cyc + 1;
        wr(4'h0, mode_word(l, 1'b1, ie));
    endtask

    task automatic check_image(input string req);
        logic [31:0] d;
        int c = cyc;
        rd(4'hC, d);
        chk(req, d, exp_word(c));
    endtask

    task automatic check_status();
        logic [31:0] d;
        int  c = cyc;
        bit  f = (periods(c) - base) > 0;
        logic i;
        #1 i = irq;
        chk(ie_m ? "R6 irq level" : "R7 irq masked", 32'(i), 32'(f && ie_m));
        #0;
        rd(4'h4, d);
        chk("R3 status flag", d, 32'(f));
    endtask

    task automatic ack_read();
        logic [31:0] d;
        int c = cyc;
        rd(4'h8, d);
        chk("R4 value word", d, exp_word(c));
        base = periods(c);
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        do_reset();

        // R1: reset state
        rd(4'h0, d); chk("R1 mode", d, 32'h0);
        rd(4'h4, d); chk("R1 status", d, 32'h0);
        rd(4'hC, d); chk("R1 image", d, 32'h0);
        rd(4'h8, d); chk("R1 value", d, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // Sweep over small limits, with and without interrupts
        for (int l = 0; l < 5; l++) begin
            for (int ie = 0; ie < 2; ie++) begin
                do_reset();
                start(l, ie[0]);
                for (int k = 0; k < 60; k++) begin
                    check_image("R2 R5 image");
                    check_status();
                    if (k % 7 == 6) ack_read();
                    repeat (k % 3) @(negedge clk);
                end
            end
        end

        // R10: acknowledge lands on the edge of the second wrap
        do_reset();
        start(2, 1'b1);
        wait_until(t0 + 16 * 3 * 2 - 1);
        ack_read();
        rd(4'hC, d);
        chk("R10 tally after race", 32'(d[31:20]), 32'd1);
        rd(4'h4, d);
        chk("R10 flag after race", d, 32'd1);
        chk("R10 irq after race", 32'(irq), 32'd1);

        // R9: tally wraps modulo 4096
        do_reset();
        start(0, 1'b0);
        wait_until(t0 + 16 * 4097 + 3);
        rd(4'hC, d);
        chk("R9 tally wrap", 32'(d[31:20]), 32'd1);
        rd(4'h4, d);
        chk("R9 flag", d, 32'd1);

        // R8: disable finishes the period, then halts
        do_reset();
        start(3, 1'b0);
        wait_until(t0 + 16 * 2 + 5);
        wr(4'h0, mode_word(3, 1'b0, 1'b0));
        wait_until(t0 + 60);
        rd(4'hC, d);
        chk("R8 still running", d, {12'd0, 20'd3});
        wait_until(t0 + 64);
        rd(4'hC, d);
        chk("R8 final period counted", d, {12'd1, 20'd0});
        repeat (100) @(negedge clk);
        rd(4'hC, d);
        chk("R8 halted", d, {12'd1, 20'd0});
        t0 = cyc + 1;
        wr(4'h0, mode_word(3, 1'b1, 1'b0));
        wait_until(t0 + 15);
        rd(4'hC, d);
        chk("R8 restart before tick", 32'(d[19:0]), 32'd0);
        rd(4'hC, d);
        chk("R8 restart first tick", 32'(d[19:0]), 32'd1);

        // R11: map, readback and ignored writes
        do_reset();
        start(5, 1'b1);
        rd(4'h0, d);
        chk("R11 mode readback", d, mode_word(5, 1'b1, 1'b1));
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h0, d);
        chk("R11 mode unchanged", d, mode_word(5, 1'b1, 1'b1));
        check_image("R11 image after stray writes");
        check_status();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule